// File: doc/BRIEF.md
# Time-of-Day Alarm Matcher with Wildcard Fields

This block decides, once per second, whether the clock has reached a programmed alarm time. After the timekeeping logic advances the seconds, minutes and hours bytes, it raises an update strobe. On that strobe the matcher compares each of the three time bytes with its alarm byte. If every field agrees, the block emits a single-cycle alarm event. The interrupt flag and enable logic downstream turn that event into a flag.

Any alarm byte whose two top bits are both 1 (values 0xC0 through 0xFF) is a wildcard. A wildcard field agrees with every time value. The alarm period therefore follows from which bytes are wildcarded, and no separate mode register is needed:
- no wildcards gives one event per day;
- a wildcard hour gives one event per hour;
- wildcard hour and minute give one event per minute;
- all three wildcarded gives one event on every update.

A field that is not a wildcard agrees only when its alarm byte equals its time byte bit for bit. This includes the PM flag in bit 7 of a 12-hour hours byte. The format of the bytes (binary or BCD) does not matter to the block.

The block is built around a three-state sequencer:
- **IDLE** waits for the strobe.
- **EVAL** holds the registered match result for one cycle.
- **FIRE** drives the event for one cycle.

It has these transitions:
- **SAMPLE**: IDLE to EVAL on the strobe.
- **HIT**: EVAL to FIRE when all fields agreed.
- **MISS**: EVAL to IDLE otherwise.
- **DONE**: FIRE to IDLE.
- **RESAMPLE**: FIRE to EVAL when a strobe arrives during FIRE.

Top module: `alarm_match_top`

## Requirements
- R1: After reset, `alarm_evt` is 0 and stays 0 until an update strobe has been applied.
- R2: An alarm byte with bits 7 and 6 both 1 agrees with any time byte. An alarm byte with only bit 7 set (for example 0x80) is not a wildcard.
- R3: With no wildcards, an event occurs only when seconds (field 0), minutes (field 1) and hours (field 2) all equal their alarm bytes.
- R4: With only the hours alarm byte wildcarded, an event occurs for any hour value when minutes and seconds agree.
- R5: With the hours and minutes alarm bytes wildcarded, an event occurs whenever seconds agree.
- R6: With all three alarm bytes wildcarded, every update strobe produces an event.
- R7: A non-wildcard field must match all 8 bits. An hours byte of 0x81 (PM, 1 o'clock) does not agree with an alarm byte of 0x01.
- R8: No event occurs without an update strobe, even when the alarm bytes are rewritten to agree with the current time.
- R9: The inputs are sampled at the clock edge where `upd_tick` is 1. `alarm_evt` is high for exactly one cycle, beginning one clock edge after that sampling edge. Input changes after the sampling edge do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_tick | input | 1 | One-cycle strobe after each one-second time advance |
| now_sec | input | 8 | Current seconds byte |
| now_min | input | 8 | Current minutes byte |
| now_hr | input | 8 | Current hours byte (bit 7 = PM in 12-hour mode) |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hr | input | 8 | Hours alarm byte |
| alarm_evt | output | 1 | One-cycle alarm event |

## Verification
A wrong registered match result, or a sequencer stuck in the wrong state, shows at `alarm_evt` two edges after the strobe: the event is missing, extra, or longer than one cycle. A sequencer that leaves FIRE late, or wakes without a strobe, produces a pulse in a cycle where none is expected, and the check of that same cycle catches it. Faults in the wildcard decode appear only for alarm bytes near the 0xC0 boundary or with bit 7 set. For that reason, the stimulus includes 0x80, 0xC0 and PM hour values.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;

    localparam int unsigned FIELD_W  = 8;
    localparam int unsigned N_FIELDS = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_FIRE = 2'd2
    } amatch_state_t;

    // A field is "don't care" when its two most significant bits are set.
    function automatic logic is_wildcard(input logic [FIELD_W-1:0] b);
        return (b[FIELD_W-1] & b[FIELD_W-2]);
    endfunction

endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp
    import alarm_match_pkg::*;
#(
    parameter int unsigned W = FIELD_W
) (
    input  logic [W-1:0] now_b,
    input  logic [W-1:0] alm_b,
    output logic         agree
);

    logic wild;
    logic exact;

    always_comb begin
        wild  = (alm_b[W-1] & alm_b[W-2]);
        exact = (now_b == alm_b);
        agree = wild | exact;
    end

endmodule

// File: rtl/alarm_seq.sv
module alarm_seq
    import alarm_match_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_tick,
    input  logic          all_agree,
    output logic          alarm_evt,
    output amatch_state_t state_o
);

    amatch_state_t state_q, state_d;
    logic          hit_q;
    logic          take;

    // The inputs are captured on a strobe in any state except EVAL.
    always_comb begin
        take = upd_tick && (state_q != ST_EVAL);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (upd_tick) state_d = ST_EVAL;                 // SAMPLE
            ST_EVAL: state_d = hit_q ? ST_FIRE : ST_IDLE;             // HIT / MISS
            ST_FIRE: state_d = upd_tick ? ST_EVAL : ST_IDLE;          // RESAMPLE / DONE
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hit_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take) hit_q <= all_agree;
        end
    end

    always_comb begin
        alarm_evt = (state_q == ST_FIRE);
        state_o   = state_q;
    end

endmodule

// File: rtl/alarm_match_top.sv
module alarm_match_top
    import alarm_match_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd_tick,
    input  logic [7:0] now_sec,
    input  logic [7:0] now_min,
    input  logic [7:0] now_hr,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hr,
    output logic       alarm_evt
);

    logic [N_FIELDS-1:0][FIELD_W-1:0] now_v;
    logic [N_FIELDS-1:0][FIELD_W-1:0] alm_v;
    logic [N_FIELDS-1:0]              agree_v;
    logic                             all_agree;
    amatch_state_t                    seq_state;

    // Field 0 is seconds, field 1 is minutes, field 2 is hours.
    always_comb begin
        now_v = {now_hr, now_min, now_sec};
        alm_v = {alm_hr, alm_min, alm_sec};
    end

    for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
        alarm_field_cmp #(.W(FIELD_W)) u_cmp (
            .now_b (now_v[f]),
            .alm_b (alm_v[f]),
            .agree (agree_v[f])
        );
    end

    always_comb all_agree = &agree_v;

    alarm_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_tick  (upd_tick),
        .all_agree (all_agree),
        .alarm_evt (alarm_evt),
        .state_o   (seq_state)
    );

endmodule

// File: rtl/alarm_match_chk.sv
module alarm_match_chk
    import alarm_match_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          upd_tick,
    input logic [7:0]    now_sec,
    input logic [7:0]    now_min,
    input logic [7:0]    now_hr,
    input logic [7:0]    alm_sec,
    input logic [7:0]    alm_min,
    input logic [7:0]    alm_hr,
    input logic          alarm_evt,
    input amatch_state_t st
);

    logic ok_s, ok_m, ok_h, all_ok, all_wild, idle_ready;

    always_comb begin
        ok_s       = is_wildcard(alm_sec) || (alm_sec == now_sec);
        ok_m       = is_wildcard(alm_min) || (alm_min == now_min);
        ok_h       = is_wildcard(alm_hr)  || (alm_hr  == now_hr);
        all_ok     = ok_s && ok_m && ok_h;
        all_wild   = is_wildcard(alm_sec) && is_wildcard(alm_min) && is_wildcard(alm_hr);
        idle_ready = (st != ST_EVAL);
    end

    // R9: the event never lasts more than one cycle
    a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |=> !alarm_evt);

    // R8: every event traces back to a strobe two edges earlier
    a_r8_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |-> $past(upd_tick, 2));

    // R3: every event traces back to all fields agreeing at the sampling edge
    a_r3_fields_agreed: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |-> $past(all_ok, 2));

    // R6: a sampled strobe with every field wildcarded always fires
    a_r6_all_wild_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_tick && idle_ready && all_wild) |=> ##1 alarm_evt);

endmodule

bind alarm_match_top alarm_match_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_tick  (upd_tick),
    .now_sec   (now_sec),
    .now_min   (now_min),
    .now_hr    (now_hr),
    .alm_sec   (alm_sec),
    .alm_min   (alm_min),
    .alm_hr    (alm_hr),
    .alarm_evt (alarm_evt),
    .st        (seq_state)
);

// File: tb/tb_alarm_match_top.sv
module tb_alarm_match_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd_tick = 1'b0;
    logic [7:0] now_sec = 8'h00, now_min = 8'h00, now_hr = 8'h00;
    logic [7:0] alm_sec = 8'h00, alm_min = 8'h00, alm_hr = 8'h00;
    logic       alarm_evt;

    int n_vec  = 0;
    int n_fail = 0;
    bit exp_q[$];
    string tag_q[$];
    logic h1 = 1'b0, h2 = 1'b0;

    alarm_match_top dut (
        .clk(clk), .rst_n(rst_n), .upd_tick(upd_tick),
        .now_sec(now_sec), .now_min(now_min), .now_hr(now_hr),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
        .alarm_evt(alarm_evt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench-side strobe history: h2 marks the cycle where the event belongs.
    always @(posedge clk) begin
        h2 <= h1;
        h1 <= upd_tick;
    end

    function automatic bit fld_ok(input logic [7:0] n, input logic [7:0] a);
        return (a[7:6] == 2'b11) || (a == n);
    endfunction

    // Monitor: compares the output against the scoreboard away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            n_vec++;
            if (h2) begin
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R9: event slot with empty scoreboard, actual=%0b expected=none", alarm_evt);
                end else begin
                    automatic bit e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    if (alarm_evt !== e) begin
                        n_fail++;
                        $display("FAIL %s: actual=%0b expected=%0b", t, alarm_evt, e);
                    end
                end
            end else if (alarm_evt !== 1'b0) begin
                n_fail++;
                $display("FAIL R8/R9: event outside strobe slot, actual=%0b expected=0", alarm_evt);
            end
        end
    end

    // Driver: applies one strobe and pushes the expected outcome.
    task automatic apply(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                         input logic [7:0] as, input logic [7:0] am, input logic [7:0] ah,
                         input string tag);
        @(negedge clk);
        now_sec = s; now_min = m; now_hr = h;
        alm_sec = as; alm_min = am; alm_hr = ah;
        upd_tick = 1'b1;
        exp_q.push_back(fld_ok(s, as) && fld_ok(m, am) && fld_ok(h, ah));
        tag_q.push_back(tag);
        @(negedge clk);
        upd_tick = 1'b0;
        now_sec = ~s;   // R9: change after the sampling edge must not matter
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        n_vec++;
        if (alarm_evt !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: in reset actual=%0b expected=0", alarm_evt);
        end
        rst_n = 1'b1;
        repeat (4) @(negedge clk);   // R1: monitor checks no event before any strobe

        // R3 daily exact match and mismatches
        apply(8'h59, 8'h59, 8'h23, 8'h59, 8'h59, 8'h23, "R3 exact");
        apply(8'h58, 8'h59, 8'h23, 8'h59, 8'h59, 8'h23, "R3 sec off");
        apply(8'h59, 8'h00, 8'h23, 8'h59, 8'h59, 8'h23, "R3 min off");
        apply(8'h59, 8'h59, 8'h22, 8'h59, 8'h59, 8'h23, "R3 hr off");
        // R7 PM bit
        apply(8'h10, 8'h20, 8'h81, 8'h10, 8'h20, 8'h01, "R7 PM vs AM");
        apply(8'h10, 8'h20, 8'h81, 8'h10, 8'h20, 8'h81, "R7 PM exact");
        // R4 hourly
        apply(8'h30, 8'h15, 8'h07, 8'h30, 8'h15, 8'hC0, "R4 hour wild");
        apply(8'h30, 8'h15, 8'h92, 8'h30, 8'h15, 8'hC0, "R4 hour wild pm");
        apply(8'h31, 8'h15, 8'h07, 8'h30, 8'h15, 8'hC0, "R4 sec off");
        // R5 per minute
        apply(8'h05, 8'h44, 8'h11, 8'h05, 8'hD5, 8'hFF, "R5 min+hr wild");
        apply(8'h05, 8'h00, 8'h00, 8'h05, 8'hC3, 8'hE1, "R5 min+hr wild b");
        apply(8'h06, 8'h44, 8'h11, 8'h05, 8'hD5, 8'hFF, "R5 sec off");
        // R6 every second
        apply(8'h00, 8'h00, 8'h00, 8'hFF, 8'hC0, 8'hC0, "R6 all wild");
        apply(8'h3B, 8'h17, 8'h8C, 8'hC0, 8'hFF, 8'hDE, "R6 all wild b");
        // R2 wildcard boundary
        apply(8'h12, 8'h34, 8'h05, 8'hE0, 8'h34, 8'h05, "R2 sec wild");
        apply(8'h12, 8'h34, 8'h05, 8'h80, 8'h34, 8'h05, "R2 0x80 not wild");
        apply(8'h12, 8'h34, 8'h05, 8'hBF, 8'h34, 8'h05, "R2 0xBF not wild");

        // R8: rewrite alarm bytes to match with no strobe; monitor expects 0
        @(negedge clk);
        now_sec = 8'h01; now_min = 8'h02; now_hr = 8'h03;
        alm_sec = 8'h01; alm_min = 8'h02; alm_hr = 8'h03;
        repeat (6) @(negedge clk);
        alm_sec = 8'hC0; alm_min = 8'hC0; alm_hr = 8'hC0;
        repeat (6) @(negedge clk);

        repeat (4) @(negedge clk);
        n_vec++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R9: pending expected events actual=%0d expected=0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule